// File: doc/BRIEF.md
# DMA Transfer-Condition Sequencer

This block is the control core of a small fixed-priority multi-channel DMA engine. It decides which channel may use the bus next and how long that channel keeps it. Each channel has a request line, a 2-bit transfer-condition mode, an operand-size code and a remaining byte counter. The sequencer hands the bus side one unit-transfer command at a time over a start/done handshake. Each command carries a channel number and a byte count.

The mode decides when the sequencer arbitrates again:

- In unit mode a channel moves one operand per won arbitration. Its level request is then ignored for the one arbitration slot that follows, so a lower-priority requester can get in.
- In sequential mode one request starts a run. The run competes again after every operand and comes back by itself unless a higher-priority channel is asking.
- In non-stop mode the run goes to the end with no arbitration between operands.

When a counter runs out, the channel gives a one-cycle completion pulse. It then stays idle until software gives it a new count.

Top module: `dma_cond_seq`

## Requirements
- R1: After reset no start is issued, no completion pulse is raised and every counter is zero, so requests alone start nothing.
- R2: Channel i's mode is `mode_i[2i+1:2i]`. The codes are 00 unit, 01 sequential and 10 non-stop. Code 11 behaves exactly like 00.
- R3: Channel i's operand code k is `opsz_i[2i+1:2i]` and selects 2^k bytes. The size issued on `bus_size_o` is the smaller of 2^k and the remaining count.
- R4: Each `bus_done_i` takes the issued size off the owner's counter. When the counter reaches zero, `done_pulse_o[i]` is high for exactly the one cycle after that done.
- R5: Priority is fixed, and channel 0 is the highest. A new owner is chosen only while idle or at a unit boundary.
- R6: In unit mode a win moves one operand. The arbitration slot right after that operand ignores the channel's own request, so a lower-priority requester wins there if no higher one is asking.
- R7: In sequential mode a single request starts a run that continues until the counter is zero even after the request drops. After every operand a higher-priority request takes the bus. A lower-priority request never takes it before the run ends.
- R8: In non-stop mode the next start follows one cycle after each done. No other channel gets in until the counter reaches zero.
- R9: A channel with a zero counter ignores its request. `load_i[i]` loads `load_cnt_i` only when channel i's counter is zero and is ignored otherwise.
- R10: At most one unit is outstanding. `bus_start_o` is a one-cycle pulse, and in every mode but non-stop the next start comes no earlier than two cycles after a done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NCH | Level-sensed request per channel |
| mode_i | input | 2*NCH | Transfer-condition mode per channel |
| opsz_i | input | OPSZ_W*NCH | Operand-size code per channel |
| load_i | input | NCH | Counter load strobe per channel |
| load_cnt_i | input | CNT_W | Byte count to load |
| bus_start_o | output | 1 | One-cycle unit-transfer command |
| bus_ch_o | output | CH_W | Channel of the current unit |
| bus_size_o | output | BYTES_W | Byte count of the current unit |
| bus_done_i | input | 1 | Bus side finished the current unit |
| done_pulse_o | output | NCH | One-cycle completion pulse per channel |

## Verification
The assertions check the following on every cycle:

- The start is a single-cycle pulse that never coincides with a done.
- Completion pulses are one-hot and last one cycle.
- Each issued size is non-zero, within the largest operand and never beyond the remaining count.
- A counter moves only on a done or on a load into an empty channel.
- Non-stop runs restart on the cycle after each done.

Only the directed scenarios can show the order in which channels take the bus, because that order depends on the request history:

- the mask slot after a unit-mode operand letting a lower channel in;
- a sequential run surviving a dropped request while a higher channel preempts it;
- a clipped final unit;
- ignored loads.

// File: rtl/dma_cond_pkg.sv
package dma_cond_pkg;

    typedef enum logic [1:0] {
        MODE_UNIT     = 2'b00,
        MODE_SEQ      = 2'b01,
        MODE_NONSTOP  = 2'b10,
        MODE_UNIT_ALT = 2'b11
    } mode_e;

    typedef enum logic {
        ST_ARB  = 1'b0,
        ST_BUSY = 1'b1
    } seq_st_e;

endpackage

// File: rtl/dma_cond_arb.sv
module dma_cond_arb #(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input  logic [NCH-1:0]  elig_i,
    output logic            grant_v_o,
    output logic [CH_W-1:0] grant_o
);

    // Lowest index wins: scan from the top so the last hit is the winner.
    always_comb begin
        grant_v_o = |elig_i;
        grant_o   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (elig_i[i]) grant_o = CH_W'(i);
        end
    end

endmodule

// File: rtl/dma_cond_chan.sv
module dma_cond_chan #(
    parameter int CNT_W   = 16,
    parameter int BYTES_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [CNT_W-1:0]   load_val_i,
    input  logic               dec_i,
    input  logic [BYTES_W-1:0] dec_amt_i,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               active_o,
    output logic               fin_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fin;
    } chan_t;

    chan_t d, q;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        if (dec_i) begin
            d.cnt = q.cnt - CNT_W'(dec_amt_i);
            if (d.cnt == '0) d.fin = 1'b1;
        end else if (load_i && q.cnt == '0) begin
            d.cnt = load_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt_o    = q.cnt;
    assign active_o = (q.cnt != '0);
    assign fin_o    = q.fin;

    // R3: a unit never takes more bytes than remain
    assert_no_overdraw_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> (CNT_W'(dec_amt_i) <= cnt_o) && (dec_amt_i != '0));

    // R4: completion is a single-cycle pulse
    assert_fin_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |=> !fin_o);

    // R9: the counter changes only on a done or on a load into an empty channel
    assert_cnt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_i && !(load_i && cnt_o == '0)) |=> $stable(cnt_o));

endmodule

// File: rtl/dma_cond_seq.sv
module dma_cond_seq
    import dma_cond_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CNT_W  = 16,
    parameter int OPSZ_W = 2,
    localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int MAXB    = 1 << ((1 << OPSZ_W) - 1),
    localparam int BYTES_W = $clog2(MAXB + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        req_i,
    input  logic [2*NCH-1:0]      mode_i,
    input  logic [OPSZ_W*NCH-1:0] opsz_i,
    input  logic [NCH-1:0]        load_i,
    input  logic [CNT_W-1:0]      load_cnt_i,
    output logic                  bus_start_o,
    output logic [CH_W-1:0]       bus_ch_o,
    output logic [BYTES_W-1:0]    bus_size_o,
    input  logic                  bus_done_i,
    output logic [NCH-1:0]        done_pulse_o
);

    typedef struct packed {
        seq_st_e          st;
        logic             start;
        logic [CH_W-1:0]  ch;
        logic [BYTES_W-1:0] size;
        logic [NCH-1:0]   mask;
        logic [NCH-1:0]   run;
    } seq_t;

    seq_t d, q;

    logic [1:0]        mode_ch [NCH];
    logic [OPSZ_W-1:0] opsz_ch [NCH];
    logic [CNT_W-1:0]  cnt     [NCH];
    logic [NCH-1:0]    active;
    logic [NCH-1:0]    dec_vec;
    logic [NCH-1:0]    elig;
    logic              win_v;
    logic [CH_W-1:0]   win;
    logic              done_acc;

    function automatic logic [BYTES_W-1:0] clip_size(input logic [OPSZ_W-1:0] code,
                                                     input logic [CNT_W-1:0] left);
        logic [BYTES_W-1:0] opb;
        opb = BYTES_W'(1) << code;
        if (left < CNT_W'(opb)) return left[BYTES_W-1:0];
        return opb;
    endfunction

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign mode_ch[g] = mode_i[2*g +: 2];
        assign opsz_ch[g] = opsz_i[OPSZ_W*g +: OPSZ_W];

        dma_cond_chan #(.CNT_W(CNT_W), .BYTES_W(BYTES_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (load_i[g]),
            .load_val_i (load_cnt_i),
            .dec_i      (dec_vec[g]),
            .dec_amt_i  (q.size),
            .cnt_o      (cnt[g]),
            .active_o   (active[g]),
            .fin_o      (done_pulse_o[g])
        );
    end

    assign done_acc = (q.st == ST_BUSY) && bus_done_i;

    always_comb begin
        dec_vec = '0;
        if (done_acc) dec_vec[q.ch] = 1'b1;
    end

    assign elig = active & (req_i | q.run) & ~q.mask;

    dma_cond_arb #(.NCH(NCH), .CH_W(CH_W)) u_arb (
        .elig_i    (elig),
        .grant_v_o (win_v),
        .grant_o   (win)
    );

    always_comb begin
        logic [CNT_W-1:0] rem;
        d       = q;
        d.start = 1'b0;
        d.mask  = '0;
        rem     = cnt[q.ch] - CNT_W'(q.size);
        unique case (q.st)
            ST_ARB: begin
                if (win_v) begin
                    d.st    = ST_BUSY;
                    d.start = 1'b1;
                    d.ch    = win;
                    d.size  = clip_size(opsz_ch[win], cnt[win]);
                    if (mode_ch[win] == MODE_SEQ || mode_ch[win] == MODE_NONSTOP)
                        d.run[win] = 1'b1;
                end
            end
            ST_BUSY: begin
                if (bus_done_i) begin
                    if (rem == '0) begin
                        d.run[q.ch] = 1'b0;
                        d.st        = ST_ARB;
                    end else if (mode_ch[q.ch] == MODE_NONSTOP) begin
                        d.start = 1'b1;
                        d.size  = clip_size(opsz_ch[q.ch], rem);
                    end else begin
                        d.st = ST_ARB;
                        if (mode_ch[q.ch] != MODE_SEQ) d.mask[q.ch] = 1'b1;
                    end
                end
            end
            default: d.st = ST_ARB;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_start_o = q.start;
    assign bus_ch_o    = q.ch;
    assign bus_size_o  = q.size;

    // R10: start is a single-cycle pulse and never overlaps a done
    assert_start_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start_o |=> !bus_start_o);
    assert_start_no_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start_o |-> !bus_done_i);

    // R4: at most one channel completes per cycle
    assert_pulse_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_pulse_o));

    // R3: issued sizes lie between one byte and the largest operand
    assert_size_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start_o |-> (bus_size_o != '0) && (int'(bus_size_o) <= MAXB));

    // R9: only a channel with bytes left is ever started
    assert_start_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start_o |-> active[bus_ch_o]);

    // R8: a non-stop run restarts the cycle after each done, on the same channel
    assert_nonstop_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_acc && mode_ch[bus_ch_o] == MODE_NONSTOP && cnt[bus_ch_o] != CNT_W'(bus_size_o))
        |=> bus_start_o && $stable(bus_ch_o));

endmodule

// File: tb/dma_cond_seq_tb.sv
module dma_cond_seq_tb;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req = '0;
    logic [7:0]  mode = '0;
    logic [7:0]  opsz = '0;
    logic [3:0]  load = '0;
    logic [15:0] load_cnt = '0;
    logic        bus_done = 1'b0;
    logic        bus_start;
    logic [1:0]  bus_ch;
    logic [3:0]  bus_size;
    logic [3:0]  done_pulse;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dma_cond_seq #(.NCH(NCH), .CNT_W(16), .OPSZ_W(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .mode_i(mode), .opsz_i(opsz),
        .load_i(load), .load_cnt_i(load_cnt), .bus_start_o(bus_start),
        .bus_ch_o(bus_ch), .bus_size_o(bus_size), .bus_done_i(bus_done),
        .done_pulse_o(done_pulse)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic setup(input int ch, input logic [1:0] m, input logic [1:0] sz, input int cnt);
        mode[2*ch +: 2] = m;
        opsz[2*ch +: 2] = sz;
        load_cnt = 16'(cnt);
        load[ch] = 1'b1;
        @(negedge clk);
        load = '0;
    endtask

    // Waits for a start, answers with a done, reports channel, size,
    // completion pulses and whether the next start followed at once.
    task automatic run_unit(output int ch, output int sz, output int pulse, output int nxt);
        bit got;
        got = bus_start;
        for (int w = 0; w < 30 && !got; w++) begin
            @(negedge clk);
            got = bus_start;
        end
        ch = -1; sz = 0; pulse = 0; nxt = 0;
        if (got) begin
            ch = int'(bus_ch);
            sz = int'(bus_size);
            @(negedge clk);
            bus_done = 1'b1;
            @(negedge clk);
            bus_done = 1'b0;
            pulse = int'(done_pulse);
            nxt = int'(bus_start);
        end
    endtask

    task automatic t_reset;
        chk("R1 start after reset", int'(bus_start), 0);
        chk("R1 pulses after reset", int'(done_pulse), 0);
        req = 4'hF;
        repeat (5) @(negedge clk);
        chk("R1 no start with zero counters", int'(bus_start), 0);
        req = '0;
    endtask

    task automatic t_unit_clip;
        int ch, sz, p, n;
        int exp_sz [3] = '{2, 2, 1};
        setup(1, 2'b00, 2'b01, 5);
        req[1] = 1'b1;
        for (int k = 0; k < 3; k++) begin
            run_unit(ch, sz, p, n);
            chk("R3 unit channel", ch, 1);
            chk("R3 clipped size", sz, exp_sz[k]);
            chk("R10 no immediate restart", n, 0);
            chk("R4 pulse timing", p, (k == 2) ? 4'b0010 : 0);
        end
        run_unit(ch, sz, p, n);
        chk("R9 zero counter ignores request", ch, -1);
        req = '0;
    endtask

    task automatic t_unit_mask;
        int ch, sz, p, n;
        int exp_ch [6] = '{0, 2, 0, 2, 0, 0};
        setup(0, 2'b00, 2'b00, 4);
        setup(2, 2'b11, 2'b00, 2);
        req = 4'b0101;
        for (int k = 0; k < 6; k++) begin
            run_unit(ch, sz, p, n);
            chk("R6 mask slot order", ch, exp_ch[k]);
            if (k == 3) chk("R2 code 11 as unit done", p, 4'b0100);
            if (k == 5) chk("R4 ch0 done", p, 4'b0001);
        end
        req = '0;
    endtask

    task automatic t_seq_hold;
        int ch, sz, p, n;
        int exp_ch [4] = '{0, 0, 0, 2};
        setup(0, 2'b01, 2'b00, 3);
        setup(2, 2'b00, 2'b00, 1);
        req = 4'b0101;
        @(negedge clk);
        req[0] = 1'b0;
        for (int k = 0; k < 4; k++) begin
            run_unit(ch, sz, p, n);
            chk("R7 run keeps bus", ch, exp_ch[k]);
            if (k == 0) chk("R7 seq re-arbitrates", n, 0);
        end
        req = '0;
    endtask

    task automatic t_seq_preempt;
        int ch, sz, p, n;
        int exp_ch [4] = '{2, 1, 2, 2};
        int exp_sz [4] = '{4, 1, 4, 2};
        setup(2, 2'b01, 2'b10, 10);
        setup(1, 2'b00, 2'b00, 1);
        req[2] = 1'b1;
        @(negedge clk);
        req[2] = 1'b0;
        for (int k = 0; k < 4; k++) begin
            run_unit(ch, sz, p, n);
            chk("R5 higher preempts run", ch, exp_ch[k]);
            chk("R3 operand size", sz, exp_sz[k]);
            if (k == 0) req[1] = 1'b1;
            if (k == 1) chk("R4 ch1 done", p, 4'b0010);
            if (k == 3) chk("R7 run ends with done", p, 4'b0100);
        end
        req = '0;
    endtask

    task automatic t_nonstop;
        int ch, sz, p, n;
        int exp_ch [4] = '{3, 3, 3, 0};
        setup(3, 2'b10, 2'b00, 3);
        setup(0, 2'b00, 2'b00, 1);
        req[3] = 1'b1;
        @(negedge clk);
        req[3] = 1'b0;
        for (int k = 0; k < 4; k++) begin
            run_unit(ch, sz, p, n);
            chk("R8 non-stop order", ch, exp_ch[k]);
            if (k < 2) chk("R8 back-to-back start", n, 1);
            if (k == 0) req[0] = 1'b1;
        end
        req = '0;
    endtask

    task automatic t_load_ignore;
        int ch, sz, p, n;
        setup(1, 2'b00, 2'b00, 2);
        setup(1, 2'b00, 2'b00, 9);
        req[1] = 1'b1;
        for (int k = 0; k < 2; k++) begin
            run_unit(ch, sz, p, n);
            chk("R9 loaded channel runs", ch, 1);
        end
        chk("R9 second load ignored", p, 4'b0010);
        run_unit(ch, sz, p, n);
        chk("R9 nothing after count", ch, -1);
        req = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unit_clip();
        t_unit_mask();
        t_seq_hold();
        t_seq_preempt();
        t_nonstop();
        t_load_ignore();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule